// File: doc/BRIEF.md
# Matrix Accelerator Macro-Instruction Sequencer

This controller pulls compact 12-bit macro instructions from a host-side queue and turns each one into a timed sequence of row requests for the accelerator's datapath units: the host-memory reader, the weight path, the matrix array, the vector unit and the host-memory writer. Every instruction names an operation, a row count, an accumulator slot and a unified-buffer slot. The sequencer holds the request for one row until the selected unit acknowledges it, steps to the next row, and signals completion before it takes the next instruction.

Each instruction runs through the same fixed phases. It is fetched, spends two cycles in decode and setup, issues one request per row, and then spends two cycles in drain. A matrix multiply waits in setup while a weight load issued earlier has not yet been reported as landed in the array. Codes outside the defined set are flagged and dropped. A typical layer is issued as host read, weight read, multiply, activate and write-back.

Top module: `mseq_top`

## Requirements
- R1: The instruction word is split as bits [11:9] operation code, [8:5] length, [4:3] accumulator slot, [2:0] unified-buffer slot. `ubAddr` and `accAddr` carry the latched slots while requests are issued.
- R2: The operation code selects one request line. 000 selects `hostRdReq`, 001 selects `wgtRdReq`, 010 and 011 select `mmReq`, 100 selects `actReq` and 110 selects `hostWrReq`. `accumEn` is high during requests only for code 011.
- R3: `instrPop` is high only when the sequencer is idle and `instrValid` is high. A queue held non-empty during an instruction is not popped again until that instruction ends.
- R4: With no stall, an instruction is busy for 2 setup cycles, then its row cycles, then 2 drain cycles. `done` is a one-cycle pulse in the last busy cycle, so 8 rows with immediate acknowledges take 12 cycles.
- R5: The length field holds the row count minus one (1 to 16 rows). `rowIdx` counts from 0, and a request stays high with `rowIdx` unchanged until `dpAck` is seen.
- R6: At most one request line is high in any cycle.
- R7: After a weight-read instruction completes, a multiply (010 or 011) stays in setup with no request until `wgtLoadDone` has been seen. It leaves setup one cycle after that pulse.
- R8: Codes 101 and 111 raise `illegalErr` for one cycle one cycle after the fetch. They issue no request and no `done`, and the sequencer is idle again in the following cycle.
- R9: `busy` is high from the cycle after a fetch through the cycle carrying `done`.
- R10: After reset the sequencer is idle: `busy`, `done`, `illegalErr` and all requests are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction queue has a word |
| instrWord | input | 12 | Head-of-queue instruction |
| instrPop | output | 1 | Pops the queue head this cycle |
| dpAck | input | 1 | Acknowledge from the selected datapath unit for the current row |
| wgtLoadDone | input | 1 | Pulse from the weight path: pending weights are now in the array |
| hostRdReq | output | 1 | Row request to the host-memory reader |
| wgtRdReq | output | 1 | Row request to the weight path |
| mmReq | output | 1 | Row request to the matrix array |
| actReq | output | 1 | Row request to the vector unit |
| hostWrReq | output | 1 | Row request to the host-memory writer |
| accumEn | output | 1 | Multiply adds into the accumulator slot instead of overwriting it |
| ubAddr | output | 3 | Unified-buffer slot of the current instruction |
| accAddr | output | 2 | Accumulator slot of the current instruction |
| rowIdx | output | 4 | Index of the row being requested |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Completion pulse |
| illegalErr | output | 1 | Undefined operation code was dropped |

## Verification
The properties assume that `dpAck` describes only the row request that is currently raised, and that a queue word stays put while `instrValid` is high. The bench drives the acknowledge low in every cycle with no request and high only in the cycle it accepts a row. It changes `instrWord` only at a falling edge while the sequencer is idle or has just popped it. `wgtLoadDone` is pulsed only while a weight load is pending, so the stall property sees a clean set-then-clear sequence.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int OP_W = 3;
  localparam int NUM_UNITS = 5;

  localparam logic [OP_W-1:0] OP_RDHOST = 3'b000;
  localparam logic [OP_W-1:0] OP_RDWGT  = 3'b001;
  localparam logic [OP_W-1:0] OP_MM     = 3'b010;
  localparam logic [OP_W-1:0] OP_MMACC  = 3'b011;
  localparam logic [OP_W-1:0] OP_ACT    = 3'b100;
  localparam logic [OP_W-1:0] OP_WRHOST = 3'b110;

  // Target unit; the numeric value minus one is the request-vector bit.
  typedef enum logic [2:0] {
    U_NONE   = 3'd0,
    U_HOSTRD = 3'd1,
    U_WGT    = 3'd2,
    U_MM     = 3'd3,
    U_ACT    = 3'd4,
    U_HOSTWR = 3'd5
  } unitE;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETUP,
    S_ROWS,
    S_DRAIN
  } seqStateE;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadInstr;
    logic incRow;
    logic rowActive;
  } ctrlStrobeT;

  function automatic unitE opToUnit(input logic [OP_W-1:0] op);
    unitE u;
    case (op)
      OP_RDHOST:      u = U_HOSTRD;
      OP_RDWGT:       u = U_WGT;
      OP_MM, OP_MMACC: u = U_MM;
      OP_ACT:         u = U_ACT;
      OP_WRHOST:      u = U_HOSTWR;
      default:        u = U_NONE;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/mseq_datapath.sv
module mseq_datapath
  import mseq_pkg::*;
#(
  parameter int UB_AW  = 3,
  parameter int ACC_AW = 2,
  parameter int LEN_W  = 4,
  localparam int IW    = OP_W + LEN_W + ACC_AW + UB_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IW-1:0]     instrWord,
  input  ctrlStrobeT        strobe,
  output logic [OP_W-1:0]   opCode,
  output logic              lastRow,
  output logic [NUM_UNITS-1:0] reqVec,
  output logic              accumEn,
  output logic [UB_AW-1:0]  ubAddr,
  output logic [ACC_AW-1:0] accAddr,
  output logic [LEN_W-1:0]  rowIdx
);

  localparam int LEN_LSB = UB_AW + ACC_AW;

  logic [OP_W-1:0]   opReg;
  logic [LEN_W-1:0]  lenReg;
  logic [ACC_AW-1:0] accReg;
  logic [UB_AW-1:0]  ubReg;
  logic [LEN_W-1:0]  rowCnt;
  unitE              unitSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg  <= '0;
      lenReg <= '0;
      accReg <= '0;
      ubReg  <= '0;
      rowCnt <= '0;
    end else if (strobe.loadInstr) begin
      opReg  <= instrWord[IW-1 -: OP_W];
      lenReg <= instrWord[LEN_LSB +: LEN_W];
      accReg <= instrWord[UB_AW +: ACC_AW];
      ubReg  <= instrWord[0 +: UB_AW];
      rowCnt <= '0;
    end else if (strobe.incRow) begin
      rowCnt <= rowCnt + 1'b1;
    end
  end

  assign unitSel = opToUnit(opReg);

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_req
    assign reqVec[i] = strobe.rowActive && (unitSel == unitE'(3'(i + 1)));
  end

  assign accumEn = strobe.rowActive && (opReg == OP_MMACC);
  assign opCode  = opReg;
  assign lastRow = (rowCnt == lenReg);
  assign ubAddr  = ubReg;
  assign accAddr = accReg;
  assign rowIdx  = rowCnt;

endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int DRAIN_CYC = 2,
  localparam int MAXPH = (SETUP_CYC > DRAIN_CYC) ? SETUP_CYC : DRAIN_CYC,
  localparam int CNT_W = $clog2(MAXPH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrValid,
  input  logic            dpAck,
  input  logic            wgtLoadDone,
  input  logic [OP_W-1:0] opCode,
  input  logic            lastRow,
  output ctrlStrobeT      strobe,
  output logic            instrPop,
  output logic            busy,
  output logic            done,
  output logic            illegalErr
);

  seqStateE   state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic       wgtPending;
  unitE       unitSel;

  assign unitSel = opToUnit(opCode);

  always_comb begin
    nextState  = state;
    nextCnt    = cnt;
    strobe     = '0;
    instrPop   = 1'b0;
    done       = 1'b0;
    illegalErr = 1'b0;
    case (state)
      S_IDLE: begin
        if (instrValid) begin
          instrPop         = 1'b1;
          strobe.loadInstr = 1'b1;
          nextState        = S_SETUP;
          nextCnt          = '0;
        end
      end
      S_SETUP: begin
        if (unitSel == U_NONE) begin
          illegalErr = 1'b1;
          nextState  = S_IDLE;
        end else if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          if (!(unitSel == U_MM && wgtPending)) nextState = S_ROWS;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      S_ROWS: begin
        strobe.rowActive = 1'b1;
        if (dpAck) begin
          if (lastRow) begin
            nextState = S_DRAIN;
            nextCnt   = '0;
          end else begin
            strobe.incRow = 1'b1;
          end
        end
      end
      default: begin
        if (cnt == CNT_W'(DRAIN_CYC - 1)) begin
          done      = 1'b1;
          nextState = S_IDLE;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      wgtPending <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      if (done && unitSel == U_WGT) wgtPending <= 1'b1;
      else if (wgtLoadDone)          wgtPending <= 1'b0;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int UB_AW     = 3,
  parameter int ACC_AW    = 2,
  parameter int LEN_W     = 4,
  parameter int SETUP_CYC = 2,
  parameter int DRAIN_CYC = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              instrValid,
  input  logic [OP_W+LEN_W+ACC_AW+UB_AW-1:0] instrWord,
  output logic                              instrPop,
  input  logic                              dpAck,
  input  logic                              wgtLoadDone,
  output logic                              hostRdReq,
  output logic                              wgtRdReq,
  output logic                              mmReq,
  output logic                              actReq,
  output logic                              hostWrReq,
  output logic                              accumEn,
  output logic [UB_AW-1:0]                  ubAddr,
  output logic [ACC_AW-1:0]                 accAddr,
  output logic [LEN_W-1:0]                  rowIdx,
  output logic                              busy,
  output logic                              done,
  output logic                              illegalErr
);

  ctrlStrobeT           strobe;
  logic [OP_W-1:0]      opCode;
  logic                 lastRow;
  logic [NUM_UNITS-1:0] reqVec;

  mseq_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .DRAIN_CYC(DRAIN_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .dpAck(dpAck),
    .wgtLoadDone(wgtLoadDone), .opCode(opCode), .lastRow(lastRow),
    .strobe(strobe), .instrPop(instrPop), .busy(busy), .done(done),
    .illegalErr(illegalErr)
  );

  mseq_datapath #(
    .UB_AW(UB_AW), .ACC_AW(ACC_AW), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .strobe(strobe),
    .opCode(opCode), .lastRow(lastRow), .reqVec(reqVec), .accumEn(accumEn),
    .ubAddr(ubAddr), .accAddr(accAddr), .rowIdx(rowIdx)
  );

  assign hostRdReq = reqVec[0];
  assign wgtRdReq  = reqVec[1];
  assign mmReq     = reqVec[2];
  assign actReq    = reqVec[3];
  assign hostWrReq = reqVec[4];

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             instrValid,
  input logic             instrPop,
  input logic             dpAck,
  input logic             hostRdReq,
  input logic             wgtRdReq,
  input logic             mmReq,
  input logic             actReq,
  input logic             hostWrReq,
  input logic             accumEn,
  input logic [LEN_W-1:0] rowIdx,
  input logic             busy,
  input logic             done,
  input logic             illegalErr
);

  logic anyReq;
  assign anyReq = hostRdReq | wgtRdReq | mmReq | actReq | hostWrReq;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hostRdReq, wgtRdReq, mmReq, actReq, hostWrReq})); // R6
  AST_POP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    instrPop |-> (instrValid && !busy)); // R3
  AST_BUSY_AFTER_POP: assert property (@(posedge clk) disable iff (!rstN)
    instrPop |=> busy); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (anyReq && !dpAck) |=> (anyReq && $stable(rowIdx))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R4
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegalErr |-> (!anyReq && !done)); // R8
  AST_ACC_WITH_MM: assert property (@(posedge clk) disable iff (!rstN)
    accumEn |-> mmReq); // R2

endmodule

bind mseq_top mseq_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrPop(instrPop),
  .dpAck(dpAck), .hostRdReq(hostRdReq), .wgtRdReq(wgtRdReq), .mmReq(mmReq),
  .actReq(actReq), .hostWrReq(hostWrReq), .accumEn(accumEn), .rowIdx(rowIdx),
  .busy(busy), .done(done), .illegalErr(illegalErr)
);

// File: tb/mseq_top_tb.sv
`timescale 1ns/1ps
module mseq_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [11:0] instrWord = '0;
  logic        instrPop;
  logic        dpAck = 1'b0;
  logic        wgtLoadDone = 1'b0;
  logic        hostRdReq, wgtRdReq, mmReq, actReq, hostWrReq, accumEn;
  logic [2:0]  ubAddr;
  logic [1:0]  accAddr;
  logic [3:0]  rowIdx;
  logic        busy, done, illegalErr;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  mseq_top u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrPop(instrPop), .dpAck(dpAck), .wgtLoadDone(wgtLoadDone),
    .hostRdReq(hostRdReq), .wgtRdReq(wgtRdReq), .mmReq(mmReq), .actReq(actReq),
    .hostWrReq(hostWrReq), .accumEn(accumEn), .ubAddr(ubAddr), .accAddr(accAddr),
    .rowIdx(rowIdx), .busy(busy), .done(done), .illegalErr(illegalErr)
  );

  // Vector table: instruction word, and whether a weight-landed pulse follows
  localparam int NVEC = 8;
  localparam logic [11:0] VEC_WORD [NVEC] = '{
    12'b000_0111_00_101,  // host read, 8 rows
    12'b001_0011_10_011,  // weight read, 4 rows
    12'b010_0000_01_010,  // multiply, 1 row
    12'b011_1111_11_111,  // multiply-accumulate, 16 rows
    12'b100_0101_10_001,  // activate, 6 rows
    12'b110_0111_00_000,  // write back, 8 rows
    12'b001_0001_01_100,  // weight read, 2 rows
    12'b011_0010_10_110   // multiply-accumulate, 3 rows
  };
  localparam bit VEC_LOAD [NVEC] = '{0, 1, 0, 0, 0, 0, 1, 0};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expLine(input logic [2:0] op);
    case (op)
      3'b000: return 0;
      3'b001: return 1;
      3'b010, 3'b011: return 2;
      3'b100: return 3;
      3'b110: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic runInstr(input logic [11:0] w, input int gap, input int stallK,
                          input bit keepValid);
    logic [2:0] op = w[11:9];
    int rows   = int'(w[8:5]) + 1;
    int line   = expLine(op);
    int setupC = (stallK > 0) ? stallK + 1 : 2;
    int expBusy = setupC + rows * (gap + 1) + 2;
    int busyN = 0, doneAt = 0, doneN = 0, hand = 0, waitC = 0;
    int firstReq = 0, popsBusy = 0;
    bit finished = 0;
    logic [4:0] rv;
    @(negedge clk);
    instrWord  = w;
    instrValid = 1'b1;
    #0.5;
    chk(instrPop == 1'b1, "R3", "pop when idle", int'(instrPop), 1);
    @(negedge clk);
    if (!keepValid) instrValid = 1'b0;
    for (int guard = 0; guard < 400; guard++) begin
      if (!busy) begin finished = 1; break; end
      busyN++;
      if (instrPop) popsBusy++;
      rv = {hostWrReq, actReq, mmReq, wgtRdReq, hostRdReq};
      if (rv != 5'b0) begin
        if (firstReq == 0) firstReq = busyN;
        chk(rv == (5'b1 << line), "R2", "request line", int'(rv), 1 << line);
        chk(ubAddr == w[2:0] && accAddr == w[4:3], "R1", "slot fields",
            int'({accAddr, ubAddr}), int'(w[4:0]));
        chk(rowIdx == 4'(hand), "R5", "row index", int'(rowIdx), hand);
        chk(accumEn == (op == 3'b011), "R2", "accumulate flag", int'(accumEn),
            int'(op == 3'b011));
        if (waitC == gap) begin dpAck = 1'b1; hand++; waitC = 0; end
        else begin dpAck = 1'b0; waitC++; end
      end else begin
        dpAck = 1'b0;
      end
      wgtLoadDone = (stallK > 0 && busyN == stallK);
      if (done) begin doneN++; doneAt = busyN; end
      @(negedge clk);
    end
    dpAck = 1'b0; wgtLoadDone = 1'b0; instrValid = 1'b0;
    chk(finished, "R4", "instruction finished before watchdog", int'(finished), 1);
    chk(busyN == expBusy, (stallK > 0) ? "R7" : "R4", "busy cycles", busyN, expBusy);
    chk(doneN == 1 && doneAt == expBusy, "R4", "done pulse cycle", doneAt, expBusy);
    chk(hand == rows, "R5", "rows handshaked", hand, rows);
    chk(firstReq == setupC + 1, (stallK > 0) ? "R7" : "R9", "first request cycle",
        firstReq, setupC + 1);
    chk(popsBusy == 0, "R3", "pops while busy", popsBusy, 0);
  endtask

  task automatic pulseLoad();
    @(negedge clk);
    wgtLoadDone = 1'b1;
    @(negedge clk);
    wgtLoadDone = 1'b0;
  endtask

  task automatic runIllegal(input logic [11:0] w);
    @(negedge clk);
    instrWord = w; instrValid = 1'b1;
    #0.5;
    chk(instrPop == 1'b1, "R3", "pop of undefined code", int'(instrPop), 1);
    @(negedge clk);
    instrValid = 1'b0;
    chk(busy && illegalErr, "R8", "error flag after fetch", int'({busy, illegalErr}), 3);
    chk({hostWrReq, actReq, mmReq, wgtRdReq, hostRdReq} == 5'b0 && !done, "R8",
        "no request or done", int'({done, hostWrReq, actReq, mmReq, wgtRdReq, hostRdReq}), 0);
    @(negedge clk);
    chk(!busy && !illegalErr, "R8", "idle after error", int'({busy, illegalErr}), 0);
  endtask

  initial begin
    #(100000 * 5.0);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !illegalErr, "R10", "status after reset",
        int'({busy, done, illegalErr}), 0);
    chk({hostWrReq, actReq, mmReq, wgtRdReq, hostRdReq, accumEn} == 6'b0, "R10",
        "requests after reset", int'({hostWrReq, actReq, mmReq, wgtRdReq, hostRdReq}), 0);

    for (int i = 0; i < NVEC; i++) begin
      runInstr(VEC_WORD[i], 0, 0, 1'b0);
      if (VEC_LOAD[i]) pulseLoad();
    end

    // R5: slow acknowledges, two waiting cycles per row
    runInstr(12'b100_0010_01_011, 2, 0, 1'b0);
    // R3: queue stays non-empty for the whole instruction
    runInstr(12'b000_0011_11_010, 0, 0, 1'b1);
    // R7: multiply after a weight read whose load lands late
    runInstr(12'b001_0000_00_001, 0, 0, 1'b0);
    runInstr(12'b010_0001_10_101, 0, 5, 1'b0);
    // R8: undefined codes, then a normal instruction still works
    runIllegal(12'b101_0011_01_001);
    runIllegal(12'b111_1111_11_111);
    runInstr(12'b110_0000_01_110, 0, 0, 1'b0);
    // R4: length field 7 gives 8 rows in 12 cycles
    runInstr(12'b000_0111_01_001, 0, 0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule